// File: doc/BRIEF.md
# Search Path Accelerator

This engine runs the bit-by-bit identity search over a single-wire sensor bus without a host round trip per bit. While it is enabled, the host streams bytes that carry its preferred branch for each of the 64 identity bit positions. For every position the engine asks an external slot generator for two read slots and then one write slot. It picks the written bit from the two sampled values and the host's branch, and it reports that bit together with a discrepancy flag.

Each input byte covers four consecutive positions and yields exactly one output byte with the same layout, so sixteen bytes in give sixteen bytes out for a full 64-position pass. A bus error (no device answering either read) is sticky. From then on every reported path bit is 1 until the engine is turned off, so a pass ending with both the last path bit and the last flag set is a failed pass.

Top module: `search_accel`

## Requirements
- R1: The engine is enabled or disabled by a control strobe carrying the new flag value. Out of reset it is disabled. While disabled, `in_ready_o` and `slot_req_o` stay low and input bytes are ignored. Disabling clears the sticky error and restarts at lane 0, so the next byte after re-enabling begins a fresh pass.
- R2: A byte is accepted only on a cycle with `in_valid_i` and `in_ready_o` both high. `in_ready_o` is low from the cycle after acceptance until the cycle in which that byte's result is presented.
- R3: Input byte j holds the host branch for position 4j+k in bit 2k+1, for k = 0..3. Even bits are filler and do not affect any slot or any result.
- R4: Each position issues exactly three slots in order: read, read, write. Read slots are requested with `slot_wr_o`=1. The request and its type stay stable until `slot_done_i`.
- R5: If both reads return 0 (conflict), the write slot carries the host branch bit and the discrepancy flag is 1.
- R6: If the two reads differ, the write slot carries the first read value and the discrepancy flag is 0.
- R7: If both reads return 1 (no response), the write slot carries 1, the discrepancy flag is 1, and the sticky error is set.
- R8: While the sticky error is set, every later position writes 1 and reports a path bit of 1, across pass boundaries, until the engine is disabled. The flag still follows the reads.
- R9: Output byte j holds the discrepancy flag of position 4j+k in bit 2k and the written bit in bit 2k+1. It is presented with a one-cycle `out_valid_o` pulse in the cycle after the fourth write slot completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control strobe for the enable flag |
| ctrl_flag_i | input | 1 | New enable value, taken with `ctrl_we_i` |
| in_valid_i | input | 1 | Host byte valid |
| in_byte_i | input | 8 | Host branch byte, four positions |
| in_ready_o | output | 1 | Engine can take a byte |
| slot_req_o | output | 1 | Slot request to the slot generator |
| slot_wr_o | output | 1 | Slot type: 1 = read or write-1, 0 = write-0 |
| slot_done_i | input | 1 | Requested slot finished (one-cycle pulse) |
| slot_bit_i | input | 1 | Bus value sampled in the finished slot |
| out_valid_o | output | 1 | Result byte valid, one-cycle pulse |
| out_byte_o | output | 8 | Packed flags and written bits |

## Verification
After an accepting edge, `in_ready_o` is already low one cycle later, and the first read request is up in the same cycle. After each `slot_done_i` edge, the type of the next slot is visible in the following cycle. The result byte and the return of `in_ready_o` both appear in the cycle after the edge that samples the fourth write's completion. The bench drives and samples only on falling edges. It checks every write slot's type against a bus model at the moment the model answers it. It checks each result byte on the falling edge where the pulse is first high.

// File: rtl/search_accel_pkg.sv
package search_accel_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RD0,
    PH_RD1,
    PH_WR
  } phase_e;
endpackage

// File: rtl/search_decide.sv
module search_decide (
  input  logic b0_i,
  input  logic b1_i,
  input  logic path_i,
  input  logic err_i,
  output logic wr_bit_o,
  output logic disc_o,
  output logic err_hit_o
);
  always_comb begin
    err_hit_o = b0_i & b1_i;
    disc_o    = (b0_i == b1_i);
    if (err_i || err_hit_o) wr_bit_o = 1'b1;
    else if (b0_i ^ b1_i)   wr_bit_o = b0_i;
    else                    wr_bit_o = path_i;
  end
endmodule

// File: rtl/search_lanes.sv
module search_lanes #(
  parameter int POS_PER_BYTE = 4,
  localparam int BYTE_W = 2 * POS_PER_BYTE,
  localparam int LANE_W = (POS_PER_BYTE > 1) ? $clog2(POS_PER_BYTE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              commit_i,
  input  logic              disc_i,
  input  logic              wr_bit_i,
  output logic              path_bit_o,
  output logic [BYTE_W-1:0] out_byte_o
);
  logic [POS_PER_BYTE-1:0] path_q;
  logic [POS_PER_BYTE-1:0] path_d;
  logic                    unused_filler;

  for (genvar k = 0; k < POS_PER_BYTE; k++) begin : g_lane
    logic [1:0] pair_q;
    assign path_d[k] = byte_i[2*k+1];
    assign out_byte_o[2*k +: 2] = pair_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      pair_q <= '0;
      else if (commit_i && (lane_i == LANE_W'(k)))      pair_q <= {wr_bit_i, disc_i};
    end
  end

  // even bits carry no information
  always_comb begin
    unused_filler = 1'b0;
    for (int k = 0; k < POS_PER_BYTE; k++) unused_filler = unused_filler ^ byte_i[2*k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     path_q <= '0;
    else if (load_i) path_q <= path_d;
  end

  assign path_bit_o = path_q[lane_i];
endmodule

// File: rtl/search_seq.sv
module search_seq
  import search_accel_pkg::*;
#(
  parameter int POS_PER_BYTE = 4,
  localparam int LANE_W = (POS_PER_BYTE > 1) ? $clog2(POS_PER_BYTE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              ctrl_flag_i,
  input  logic              in_valid_i,
  input  logic              slot_done_i,
  input  logic              slot_bit_i,
  input  logic              wr_bit_i,
  input  logic              disc_i,
  input  logic              err_hit_i,
  output logic              in_ready_o,
  output logic              load_o,
  output logic              slot_req_o,
  output logic              slot_wr_o,
  output logic              b0_o,
  output logic              err_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              commit_o,
  output logic              disc_o,
  output logic              wr_bit_o,
  output logic              out_valid_o
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(POS_PER_BYTE - 1);

  phase_e            state_q;
  logic              en_q, err_q, b0_q, wr_q, disc_q, out_valid_q;
  logic [LANE_W-1:0] lane_q;
  logic              kill;

  assign kill        = ctrl_we_i && !ctrl_flag_i;
  assign in_ready_o  = en_q && (state_q == PH_IDLE);
  assign load_o      = in_ready_o && in_valid_i && !kill;
  assign slot_req_o  = (state_q != PH_IDLE);
  assign slot_wr_o   = (state_q == PH_WR) ? wr_q : 1'b1;
  assign commit_o    = (state_q == PH_WR) && slot_done_i;
  assign b0_o        = b0_q;
  assign err_o       = err_q;
  assign lane_o      = lane_q;
  assign disc_o      = disc_q;
  assign wr_bit_o    = wr_q;
  assign out_valid_o = out_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PH_IDLE;
      en_q        <= 1'b0;
      err_q       <= 1'b0;
      b0_q        <= 1'b0;
      wr_q        <= 1'b1;
      disc_q      <= 1'b0;
      lane_q      <= '0;
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= 1'b0;
      if (ctrl_we_i) en_q <= ctrl_flag_i;
      if (kill) begin
        state_q <= PH_IDLE;
        err_q   <= 1'b0;
        lane_q  <= '0;
        wr_q    <= 1'b1;
      end else begin
        unique case (state_q)
          PH_IDLE: if (load_o) begin
            state_q <= PH_RD0;
            lane_q  <= '0;
          end
          PH_RD0: if (slot_done_i) begin
            b0_q    <= slot_bit_i;
            state_q <= PH_RD1;
          end
          PH_RD1: if (slot_done_i) begin
            wr_q    <= wr_bit_i;
            disc_q  <= disc_i;
            if (err_hit_i) err_q <= 1'b1;
            state_q <= PH_WR;
          end
          PH_WR: if (slot_done_i) begin
            wr_q <= 1'b1;
            if (lane_q == LAST_LANE) begin
              state_q     <= PH_IDLE;
              out_valid_q <= 1'b1;
            end else begin
              lane_q  <= lane_q + 1'b1;
              state_q <= PH_RD0;
            end
          end
          default: state_q <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/search_accel.sv
module search_accel #(
  parameter int POS_PER_BYTE = 4,
  localparam int BYTE_W = 2 * POS_PER_BYTE,
  localparam int LANE_W = (POS_PER_BYTE > 1) ? $clog2(POS_PER_BYTE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              ctrl_flag_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_byte_i,
  output logic              in_ready_o,
  output logic              slot_req_o,
  output logic              slot_wr_o,
  input  logic              slot_done_i,
  input  logic              slot_bit_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_byte_o
);
  logic              load, commit, b0, err, path_bit;
  logic              dec_wr, dec_disc, dec_err_hit, q_disc, q_wr;
  logic [LANE_W-1:0] lane;

  search_seq #(.POS_PER_BYTE(POS_PER_BYTE)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_we_i),
    .ctrl_flag_i (ctrl_flag_i),
    .in_valid_i  (in_valid_i),
    .slot_done_i (slot_done_i),
    .slot_bit_i  (slot_bit_i),
    .wr_bit_i    (dec_wr),
    .disc_i      (dec_disc),
    .err_hit_i   (dec_err_hit),
    .in_ready_o  (in_ready_o),
    .load_o      (load),
    .slot_req_o  (slot_req_o),
    .slot_wr_o   (slot_wr_o),
    .b0_o        (b0),
    .err_o       (err),
    .lane_o      (lane),
    .commit_o    (commit),
    .disc_o      (q_disc),
    .wr_bit_o    (q_wr),
    .out_valid_o (out_valid_o)
  );

  // second read is decided straight from the bus sample
  search_decide u_dec (
    .b0_i      (b0),
    .b1_i      (slot_bit_i),
    .path_i    (path_bit),
    .err_i     (err),
    .wr_bit_o  (dec_wr),
    .disc_o    (dec_disc),
    .err_hit_o (dec_err_hit)
  );

  search_lanes #(.POS_PER_BYTE(POS_PER_BYTE)) u_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .byte_i     (in_byte_i),
    .lane_i     (lane),
    .commit_i   (commit),
    .disc_i     (q_disc),
    .wr_bit_i   (q_wr),
    .path_bit_o (path_bit),
    .out_byte_o (out_byte_o)
  );
endmodule

// File: rtl/search_accel_chk.sv
module search_accel_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ctrl_we_i,
  input logic ctrl_flag_i,
  input logic in_ready_o,
  input logic slot_req_o,
  input logic slot_wr_o,
  input logic slot_done_i,
  input logic out_valid_o
);
  logic en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (ctrl_we_i) en_q <= ctrl_flag_i;
  end

  assert_disabled_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (!in_ready_o && !slot_req_o));

  assert_ready_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !slot_req_o);

  assert_slot_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_req_o && !slot_done_i && !(ctrl_we_i && !ctrl_flag_i))
      |=> (slot_req_o && $stable(slot_wr_o)));

  assert_out_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  assert_out_after_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(slot_req_o && slot_done_i));
endmodule

bind search_accel search_accel_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_flag_i (ctrl_flag_i),
  .in_ready_o  (in_ready_o),
  .slot_req_o  (slot_req_o),
  .slot_wr_o   (slot_wr_o),
  .slot_done_i (slot_done_i),
  .out_valid_o (out_valid_o)
);

// File: tb/tb_search_accel.sv
module tb_search_accel;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_LAT   = 3;
  localparam int WATCHDOG   = 150000;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0, ctrl_flag_i = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_byte_i = '0;
  logic       in_ready_o, slot_req_o, slot_wr_o, out_valid_o;
  logic       slot_done_i = 1'b0, slot_bit_i = 1'b0;
  logic [7:0] out_byte_o;

  search_accel dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .ctrl_flag_i(ctrl_flag_i),
    .in_valid_i(in_valid_i), .in_byte_i(in_byte_i), .in_ready_o(in_ready_o),
    .slot_req_o(slot_req_o), .slot_wr_o(slot_wr_o), .slot_done_i(slot_done_i),
    .slot_bit_i(slot_bit_i), .out_valid_o(out_valid_o), .out_byte_o(out_byte_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int vecs = 0, fails = 0, cyc = 0;

  // bus model state
  logic [63:0] ids [3];
  logic [2:0]  present = '0, active = '0;
  int          kill_pos = 64;
  logic [63:0] path = '0, exp_d = '0, exp_r = '0;
  logic        tb_err = 1'b0, b0m = 1'b0, b1m = 1'b0;
  int          tb_pos = 0, phase = 0, cnt = 0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic bus_read(input int ph);
    logic v = 1'b1;
    if (tb_pos >= kill_pos) return 1'b1;
    for (int i = 0; i < 3; i++)
      if (active[i]) v = v & ((ph == 0) ? ids[i][tb_pos] : ~ids[i][tb_pos]);
    return v;
  endfunction

  task automatic respond();
    logic  e;
    string tag;
    if (phase < 2) begin
      chk(slot_wr_o == 1'b1, "R4 read slot type", 64'(slot_wr_o), 64'd1);
      if (phase == 0) begin b0m = bus_read(0); slot_bit_i = b0m; end
      else            begin b1m = bus_read(1); slot_bit_i = b1m; end
      phase++;
    end else begin
      if (tb_err || (b0m && b1m)) begin e = 1'b1; tag = tb_err ? "R8 sticky write" : "R7 no-response write"; end
      else if (b0m != b1m)        begin e = b0m;  tag = "R6 single-path write"; end
      else                        begin e = path[tb_pos]; tag = "R5 conflict write"; end
      if (b0m && b1m) tb_err = 1'b1;
      chk(slot_wr_o == e, tag, 64'(slot_wr_o), 64'(e));
      exp_d[tb_pos] = (b0m == b1m);
      exp_r[tb_pos] = e;
      for (int i = 0; i < 3; i++) if (ids[i][tb_pos] != e) active[i] = 1'b0;
      slot_bit_i = 1'b0;
      phase  = 0;
      tb_pos = (tb_pos + 1) % 64;
    end
  endtask

  // slot generator model
  initial forever begin
    @(negedge clk_i);
    if (slot_done_i) begin slot_done_i = 1'b0; cnt = 0; end
    else if (slot_req_o) begin
      cnt++;
      if (cnt >= SLOT_LAT) begin respond(); slot_done_i = 1'b1; end
    end else cnt = 0;
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic set_enable(input logic flag);
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_flag_i = flag;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
    if (!flag) begin tb_err = 1'b0; tb_pos = 0; phase = 0; end
    chk(in_ready_o == flag, "R1 enable state", 64'(in_ready_o), 64'(flag));
  endtask

  task automatic send_byte(input logic [7:0] b, input string req);
    logic [7:0] exp;
    int base;
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    in_byte_i = b; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(in_ready_o == 1'b0, "R2 busy after accept", 64'(in_ready_o), 64'd0);
    while (!out_valid_o) @(negedge clk_i);
    base = (tb_pos + 60) % 64;
    for (int k = 0; k < 4; k++) begin
      exp[2*k]   = exp_d[base+k];
      exp[2*k+1] = exp_r[base+k];
    end
    chk(out_byte_o == exp, {req, " R9 packed result"}, 64'(out_byte_o), 64'(exp));
    chk(in_ready_o == 1'b1, "R2 ready with result", 64'(in_ready_o), 64'd1);
  endtask

  task automatic run_pass(input logic [63:0] p, input logic [7:0] filler, input string req);
    logic [7:0] b;
    path = p;
    if (tb_pos == 0) active = present;
    for (int j = 0; j < 16; j++) begin
      b = filler;
      for (int k = 0; k < 4; k++) b[2*k+1] = p[4*j+k];
      send_byte(b, req);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(in_ready_o == 1'b0, "R1 reset ready", 64'(in_ready_o), 64'd0);
    chk(slot_req_o == 1'b0, "R1 reset slot", 64'(slot_req_o), 64'd0);
    chk(out_valid_o == 1'b0, "R9 reset valid", 64'(out_valid_o), 64'd0);
  endtask

  task automatic t_disabled_ignore();
    in_valid_i = 1'b1; in_byte_i = 8'hFF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk(slot_req_o == 1'b0, "R1 disabled ignores byte", 64'(slot_req_o), 64'd0);
    end
    in_valid_i = 1'b0;
  endtask

  task automatic t_single();
    present = 3'b001;
    run_pass(64'h0, 8'h00, "R6");
    chk(exp_r == ids[0], "R6 path equals id", exp_r, ids[0]);
    chk(exp_d == 64'h0, "R6 no flags", exp_d, 64'h0);
  endtask

  task automatic t_two();
    present = 3'b011;
    run_pass(64'h0, 8'h00, "R5");
    chk(exp_d != 64'h0, "R5 conflicts seen", exp_d, 64'h1);
    chk(exp_r == ids[0], "R5 zero branch picks id0", exp_r, ids[0]);
    run_pass(64'hFFFF_FFFF_FFFF_FFFF, 8'h00, "R5");
    chk(exp_r == ids[1], "R5 one branch picks id1", exp_r, ids[1]);
  endtask

  task automatic t_filler();
    present = 3'b110;
    run_pass(64'h0F0F_0000_FFFF_3C3C, 8'h55, "R3");
    run_pass(64'h0F0F_0000_FFFF_3C3C, 8'hFF, "R3");
  endtask

  task automatic t_error();
    present = 3'b000;
    run_pass(64'h0, 8'h00, "R7");
    chk(exp_r == '1 && exp_d == '1, "R7 empty bus all ones", exp_r & exp_d, '1);
    present = 3'b001;
    run_pass(64'h0, 8'h00, "R8");
    chk(exp_r == '1, "R8 sticky across pass", exp_r, '1);
    set_enable(1'b0);
    set_enable(1'b1);
    run_pass(64'h0, 8'h00, "R1");
    chk(exp_r == ids[0], "R1 disable clears error", exp_r, ids[0]);
  endtask

  task automatic t_mid_error();
    present = 3'b001; kill_pos = 37;
    run_pass(64'h0, 8'h00, "R8");
    chk(exp_r[63:37] == '1, "R8 ones after error", 64'(exp_r[63:37]), 64'h7FF_FFFF);
    chk(exp_r[36:0] == ids[0][36:0], "R8 path before error", 64'(exp_r[36:0]), 64'(ids[0][36:0]));
    kill_pos = 64;
    set_enable(1'b0);
    set_enable(1'b1);
  endtask

  task automatic t_abort();
    present = 3'b100; active = present;
    send_byte(8'h00, "R1");
    send_byte(8'h00, "R1");
    set_enable(1'b0);
    set_enable(1'b1);
    run_pass(64'h0, 8'h00, "R1");
    chk(exp_r == ids[2], "R1 restart at position 0", exp_r, ids[2]);
  endtask

  initial begin
    ids[0] = 64'hA5C3_0F1E_7788_9B21;
    ids[1] = 64'hA5C3_8F1E_7708_9B23;
    ids[2] = 64'h1234_5678_9ABC_DEF0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_disabled_ignore();
    set_enable(1'b1);
    t_single();
    t_two();
    t_filler();
    t_error();
    t_mid_error();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule